// File: doc/BRIEF.md
# In-order four-stage integer pipeline with a multicycle multiplier

The block is a small in-order integer pipeline with four stages: fetch, decode with operand read, execute and write-back. It runs a short program of three-register arithmetic instructions held in an internal instruction memory. It keeps eight 16-bit general registers. Add and subtract leave execute after one cycle. Multiply keeps execute busy for three cycles, and the fetch and decode stages wait behind it. A bypass network hands a fresh result to the next instruction that needs it, so that instruction does not wait for the register file to be written.

The program and the starting register contents are written through one load port while reset is held. Releasing reset starts execution at instruction address 0. Each completed non-NOP instruction is reported on a one-cycle retire strobe together with its destination index and its result. A free-running cycle counter gives the time base for those reports. Once the program counter runs past the last loaded address, the fetch stage injects NOPs.

Top module: `pipe4_mul`

## Requirements
- R1: Cycle k is the k-th clock period after reset is released, and cycle 1 is the first fetch. An ADD or SUB that enters execute with no stall retires in the cycle after its single execute cycle. The first instruction of a program is in execute in cycle 3.
- R2: Instruction word bits [15:14] hold the opcode (00 ADD, 01 SUB, 10 MUL, 11 NOP). Bits [13:11] hold the destination, [10:8] source A and [7:5] source B, and bits [4:0] are zero. ADD produces A+B and SUB produces A-B, both modulo 2^16. MUL produces the low 16 bits of A*B.
- R3: A MUL stays in execute for three consecutive cycles. During the first two of those cycles, fetch and decode hold their contents. The next instruction enters execute in the cycle after the third MUL cycle. Two MULs in a row therefore enter execute three cycles apart.
- R4: A source register is taken from the newest older writer. The instruction in execute has priority, then the one in write-back, then the register file. A register written in write-back is already seen by a read in that same cycle. A dependent instruction right behind its producer suffers no extra delay.
- R5: The program ADD R2,R1,R0; MUL R4,R3,R2; SUB R6,R5,R4 makes its last retirement in cycle 8. Its three retirements fall in cycles 4, 7 and 8.
- R6: `ret_vld` is high for exactly one cycle per retiring non-NOP instruction, together with its `ret_dst` and `ret_val`. A NOP never raises it.
- R7: Once the program counter reaches the loaded program length, fetch supplies NOPs and the program counter stops there. No retirement follows the last program instruction.
- R8: While reset is high, `ret_vld` is 0 and `cyc_cnt` is 0. After reset, the pipeline holds only bubbles and fetch restarts at address 0. Reset clears neither the instruction memory nor the register file.
- R9: Loads take effect only while reset is high. With `ld_rf`=1, register `ld_addr[2:0]` receives `ld_data`. With `ld_rf`=0, instruction `ld_addr` receives `ld_data[15:0]`. A load to address 0 sets the program length to 1, and a load to any other address raises it to at least `ld_addr`+1. Loads made while reset is low have no effect.
- R10: `cyc_cnt` reads k-1 in cycle k and advances by one every cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; also enables loading |
| ld_we | input | 1 | Load strobe |
| ld_rf | input | 1 | Load target: 1 register file, 0 instruction memory |
| ld_addr | input | $clog2(IMEM_DEPTH) | Instruction address, or register index in bits [2:0] |
| ld_data | input | DW | Instruction word (bits [15:0]) or register value |
| ret_vld | output | 1 | Retire strobe |
| ret_dst | output | 3 | Destination of the retiring instruction |
| ret_val | output | DW | Result of the retiring instruction |
| cyc_cnt | output | CW | Cycles since reset release |

## Verification
A bench model walks each program in order. Execute for the first instruction starts in cycle 3, and every later instruction starts execute once the one before it has spent its 1 or 3 cycles there. The model predicts each retirement in the cycle after its last execute cycle, which means `cyc_cnt` reads one less than that cycle number. The bench samples the retire port at every falling edge. At each strobe it compares the destination, the value and the `cyc_cnt` reading against the next predicted entry, then checks that no retirement is missing or extra. Loads attempted while running are judged by a rerun after a bare reset, whose retirements must match the program and registers as they stood before those loads.

// File: rtl/pipe4_mul.sv
module pipe4_mul #(
  parameter int DW         = 16,
  parameter int IMEM_DEPTH = 32,
  parameter int CW         = 16,
  parameter int MUL_CYC    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld_we,
  input  logic                          ld_rf,
  input  logic [$clog2(IMEM_DEPTH)-1:0] ld_addr,
  input  logic [DW-1:0]                 ld_data,
  output logic                          ret_vld,
  output logic [2:0]                    ret_dst,
  output logic [DW-1:0]                 ret_val,
  output logic [CW-1:0]                 cyc_cnt
);

  localparam int AW  = $clog2(IMEM_DEPTH);
  localparam int MCW = $clog2(MUL_CYC);
  localparam int IW  = 11;
  localparam logic [MCW-1:0] MLAST = MCW'(MUL_CYC - 1);

  typedef enum logic [1:0] {OP_ADD = 2'b00, OP_SUB = 2'b01, OP_MUL = 2'b10, OP_NOP = 2'b11} op_t;

  localparam logic [IW-1:0] NOP_IR = {OP_NOP, 9'd0};

  logic [IW-1:0] imem [IMEM_DEPTH];
  logic [DW-1:0] rf [8];
  logic [AW:0]   pc, plen, ld_next;
  logic [IW-1:0] fetch_ir, id_ir;

  op_t           id_op, ex_op, wb_op;
  logic [2:0]    id_d, id_a, id_b, ex_d, wb_d;
  logic [DW-1:0] ex_va, ex_vb, ex_res, prod, wb_val, fwd_a, fwd_b;
  logic [MCW-1:0] mcnt;
  logic          ex_busy, ex_wr, wb_wr;

  // ---------------- fetch ----------------
  assign ld_next  = {1'b0, ld_addr} + {{AW{1'b0}}, 1'b1};
  assign fetch_ir = (pc < plen) ? imem[pc[AW-1:0]] : NOP_IR;

  // ---------------- decode ----------------
  assign id_op = op_t'(id_ir[10:9]);
  assign id_d  = id_ir[8:6];
  assign id_a  = id_ir[5:3];
  assign id_b  = id_ir[2:0];

  assign ex_wr = (ex_op != OP_NOP);
  assign wb_wr = (wb_op != OP_NOP);

  function automatic logic [DW-1:0] fwd(input logic [2:0] s);
    if (ex_wr && ex_d == s)      return ex_res;
    else if (wb_wr && wb_d == s) return wb_val;
    else                         return rf[s];
  endfunction

  assign fwd_a = fwd(id_a);
  assign fwd_b = fwd(id_b);

  // ---------------- execute ----------------
  assign prod    = ex_va * ex_vb;
  assign ex_busy = (ex_op == OP_MUL) && (mcnt != MLAST);

  always_comb begin
    case (ex_op)
      OP_ADD:  ex_res = ex_va + ex_vb;
      OP_SUB:  ex_res = ex_va - ex_vb;
      OP_MUL:  ex_res = prod;
      default: ex_res = '0;
    endcase
  end

  // ---------------- write-back / retire ----------------
  assign ret_vld = wb_wr;
  assign ret_dst = wb_d;
  assign ret_val = wb_val;

  // ---------------- storage ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_we && ld_rf) rf[ld_addr[2:0]] <= ld_data;
      if (ld_we && !ld_rf) begin
        imem[ld_addr] <= ld_data[15:5];
        if (ld_addr == '0)      plen <= {{AW{1'b0}}, 1'b1};
        else if (ld_next > plen) plen <= ld_next;
      end
    end else if (wb_wr) begin
      rf[wb_d] <= wb_val;
    end
  end

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      id_ir   <= NOP_IR;
      ex_op   <= OP_NOP;
      ex_d    <= '0;
      ex_va   <= '0;
      ex_vb   <= '0;
      mcnt    <= '0;
      wb_op   <= OP_NOP;
      wb_d    <= '0;
      wb_val  <= '0;
      cyc_cnt <= '0;
    end else begin
      cyc_cnt <= cyc_cnt + 1'b1;
      if (ex_busy) begin
        mcnt  <= mcnt + 1'b1;
        wb_op <= OP_NOP;
      end else begin
        if (pc < plen) pc <= pc + 1'b1;
        id_ir  <= fetch_ir;
        ex_op  <= id_op;
        ex_d   <= id_d;
        ex_va  <= fwd_a;
        ex_vb  <= fwd_b;
        mcnt   <= '0;
        wb_op  <= ex_op;
        wb_d   <= ex_d;
        wb_val <= ex_res;
      end
    end
  end

  // ---------------- checks ----------------
  assert_mul_bubble_R3: assert property (@(posedge clk) disable iff (rst)
    (ex_op == OP_MUL && mcnt == '0) |=> !ret_vld);

  assert_mul_retire_R3: assert property (@(posedge clk) disable iff (rst)
    (ex_op == OP_MUL && mcnt == MLAST) |=> (ret_vld && $stable(ret_dst) == 1'b0 || ret_vld));

  assert_mul_window_R3: assert property (@(posedge clk) disable iff (rst)
    mcnt < MCW'(MUL_CYC));

  assert_pc_bound_R7: assert property (@(posedge clk) disable iff (rst)
    pc <= plen);

  assert_cyc_step_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cyc_cnt == CW'($past(cyc_cnt) + 1'b1));

endmodule

// File: tb/test_pipe4_mul.sv
module test_pipe4_mul;

  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0, ld_rf = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0]   ld_data = '0;
  logic          ret_vld;
  logic [2:0]    ret_dst;
  logic [15:0]   ret_val;
  logic [15:0]   cyc_cnt;

  pipe4_mul #(.DW(16), .IMEM_DEPTH(32), .CW(16), .MUL_CYC(3)) i_pipe4_mul (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_rf(ld_rf), .ld_addr(ld_addr),
    .ld_data(ld_data), .ret_vld(ret_vld), .ret_dst(ret_dst), .ret_val(ret_val),
    .cyc_cnt(cyc_cnt));

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [15:0] prog [32];
  int          plen_b;
  logic [15:0] mreg [8];
  int          exp_d [64], exp_v [64], exp_c [64];
  int          obs_v [64], obs_c [64];
  int          nexp, last_c;

  function automatic logic [15:0] enc(int op, int d, int a, int b);
    return {op[1:0], d[2:0], a[2:0], b[2:0], 5'd0};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic build_expect();
    int e = 3;
    nexp = 0;
    last_c = 3;
    for (int i = 0; i < plen_b; i++) begin
      int op = int'(prog[i][15:14]);
      int d  = int'(prog[i][13:11]);
      int a  = int'(prog[i][10:8]);
      int b  = int'(prog[i][7:5]);
      int lat = (op == 2) ? 3 : 1;
      logic [31:0] r;
      if (op != 3) begin
        case (op)
          0: r = 32'(mreg[a]) + 32'(mreg[b]);
          1: r = 32'(mreg[a]) - 32'(mreg[b]);
          default: r = 32'(mreg[a]) * 32'(mreg[b]);
        endcase
        mreg[d] = r[15:0];
        exp_d[nexp] = d;
        exp_v[nexp] = int'(r[15:0]);
        exp_c[nexp] = e + lat - 1;
        last_c = e + lat;
        nexp++;
      end
      e += lat;
    end
  endtask

  task automatic reset_load(bit load);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(ret_vld == 1'b0, "R8", "ret_vld in reset", int'(ret_vld), 0);
    check(cyc_cnt == 16'd0, "R8", "cyc_cnt in reset", int'(cyc_cnt), 0);
    if (load) begin
      for (int r = 0; r < 8; r++) begin
        ld_we = 1'b1; ld_rf = 1'b1; ld_addr = AW'(r); ld_data = mreg[r];
        @(negedge clk);
      end
      for (int i = 0; i < plen_b; i++) begin
        ld_we = 1'b1; ld_rf = 1'b0; ld_addr = AW'(i); ld_data = prog[i];
        @(negedge clk);
      end
      ld_we = 1'b0;
    end
  endtask

  task automatic run_check(string tag);
    int idx = 0;
    rst = 1'b0;
    for (int c = 0; c < last_c + 8; c++) begin
      @(negedge clk);
      if (ret_vld) begin
        if (idx < nexp) begin
          obs_v[idx] = int'(ret_val);
          obs_c[idx] = int'(cyc_cnt);
          check(int'(ret_dst) == exp_d[idx], "R6", {tag, " dst"}, int'(ret_dst), exp_d[idx]);
          check(int'(ret_val) == exp_v[idx], "R2/R4", {tag, " value"}, int'(ret_val), exp_v[idx]);
          check(int'(cyc_cnt) == exp_c[idx], "R1/R3/R10", {tag, " retire cycle"}, int'(cyc_cnt), exp_c[idx]);
        end
        idx++;
      end
    end
    check(idx == nexp, "R6/R7", {tag, " retire count"}, idx, nexp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);

    // random programs with back-to-back dependencies
    for (int t = 0; t < 6; t++) begin
      int prev_d = 0;
      plen_b = 6 + int'($urandom % 20);
      for (int r = 0; r < 8; r++) mreg[r] = 16'($urandom);
      for (int i = 0; i < plen_b; i++) begin
        int op = int'($urandom % 4);
        int a  = ($urandom % 2 == 0) ? prev_d : int'($urandom % 8);
        int d  = int'($urandom % 8);
        prog[i] = enc(op, d, a, int'($urandom % 8));
        if (op != 3) prev_d = d;
      end
      reset_load(1'b1);
      build_expect();
      run_check("random");
    end

    // directed: back-to-back MULs, dependent after MUL, bypass priority (R3, R4)
    for (int r = 0; r < 8; r++) mreg[r] = 16'(3 + 4 * r);
    plen_b = 8;
    prog[0] = enc(2, 1, 2, 3);
    prog[1] = enc(2, 1, 1, 1);
    prog[2] = enc(0, 4, 1, 2);
    prog[3] = enc(3, 0, 0, 0);
    prog[4] = enc(1, 5, 4, 1);
    prog[5] = enc(0, 5, 5, 5);
    prog[6] = enc(1, 6, 5, 0);
    prog[7] = enc(2, 7, 6, 6);
    reset_load(1'b1);
    build_expect();
    run_check("directed");

    // worked sequence after a longer program: length rule R9, timing R5
    for (int r = 0; r < 8; r++) mreg[r] = 16'd0;
    mreg[0] = 16'd5; mreg[1] = 16'd7; mreg[3] = 16'd3; mreg[5] = 16'd100;
    plen_b = 3;
    prog[0] = enc(0, 2, 1, 0);
    prog[1] = enc(2, 4, 3, 2);
    prog[2] = enc(1, 6, 5, 4);
    reset_load(1'b1);
    build_expect();
    run_check("sequence");
    check(obs_c[0] == 3, "R5", "ADD retire cyc_cnt", obs_c[0], 3);
    check(obs_c[1] == 6, "R5", "MUL retire cyc_cnt", obs_c[1], 6);
    check(obs_c[2] == 7, "R5", "SUB retire cyc_cnt", obs_c[2], 7);
    check(obs_v[2] == 64, "R5", "SUB value", obs_v[2], 64);

    // loads while running must be ignored (R9)
    ld_we = 1'b1; ld_rf = 1'b0; ld_addr = AW'(3); ld_data = enc(0, 7, 1, 1);
    @(negedge clk);
    ld_rf = 1'b1; ld_addr = AW'(0); ld_data = 16'hBEEF;
    @(negedge clk);
    ld_we = 1'b0;
    reset_load(1'b0);
    build_expect();
    run_check("rerun");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule